// File: doc/BRIEF.md
# Packet Read-Sector Command Decoder

This block sits behind the packet-command path of an optical storage device. After a packet command has been issued with a feature byte, the twelve bytes of the command packet arrive one per valid/ready handshake. The block stores them and decodes the read-sector command (operation code 0xBE). It then issues one result. The result is either a read request, carrying the start block, sector count, sector size and data-phase mode, or an immediate completion that reports success without data or an error with a sense key and additional sense code.

Checks run in a fixed priority so that only the first failing condition is reported. A packet with any other operation code is flagged as foreign so that another decoder can handle it. The result fields stay stable until the next result, so the execution stage can read them whenever it is ready.

Top module: `pkt_read_decoder`

## Requirements
- R1: Out of reset `in_ready` is 1, `res_valid` is 0 and every result field is 0. Exactly 12 bytes are accepted per packet, with gaps between bytes allowed. In the cycle after the 12th byte is accepted, `in_ready` is 0. `res_valid` is 1 for exactly the following cycle.
- R2: All result outputs keep their values from one result pulse until the next, whatever the inputs do in between.
- R3: If bit 1 of the feature byte captured with packet byte 0 is 1, the result kind is ABORT (3) and `int_reason` is 0, ahead of every other check.
- R4: If byte 0 is not 0xBE, the result kind is OTHER (4) with `int_reason` 0.
- R5: If `media_present` is 0, the result is ERROR (2) with sense key 2 and code 0x3A, ahead of the count, range and type checks.
- R6: A sector count of zero gives OK (0) with no data, ahead of the range and type checks.
- R7: If (start + count) × 4 is greater than `capacity`, the result is ERROR with sense key 5 and code 0x21. The sum is formed without wrap-around, so a start near 2^32 fails.
- R8: Byte 9 bits [7:3] select the action. 0 gives OK. 0x02 gives READ (1) with size 2048. 0x1F gives READ with size 2352. Any other value gives ERROR with sense key 5 and code 0x24. READ is the only kind with a nonzero size.
- R9: Every result reports `start_lba` = bytes 2..5 and `sect_count` = bytes 6..8, both big-endian (byte 2 and byte 6 most significant).
- R10: `use_dma` equals bit 0 of the feature byte captured with packet byte 0.
- R11: OK and ERROR results set `int_reason` to 3'b011 (bit 1 = input direction, bit 0 = command/status). READ sets it to 3'b010. Sense key and code are 0 on any kind other than ERROR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feature | input | 8 | Feature byte of the packet command, captured with packet byte 0 |
| media_present | input | 1 | Medium is loaded |
| capacity | input | CAP_W | Medium size in 512-byte units |
| in_valid | input | 1 | Packet byte is valid |
| in_data | input | 8 | Packet byte |
| in_ready | output | 1 | Block accepts a byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 3 | 0 OK, 1 READ, 2 ERROR, 3 ABORT, 4 OTHER |
| sense_key | output | 4 | Sense key on ERROR |
| sense_asc | output | 8 | Additional sense code on ERROR |
| start_lba | output | 32 | Starting block |
| sect_count | output | 24 | Sector count |
| sect_size | output | 12 | Bytes per sector on READ |
| use_dma | output | 1 | Data phase uses DMA instead of PIO |
| int_reason | output | 3 | Interrupt-reason bits for the result |

## Verification
A byte counter that drifts by one shifts every field. Because the start block and sector count are echoed on every result, such an error shows up as a wrong `start_lba` or `sect_count` at the very next strobe, or as a strobe that comes a packet late. A broken priority or a range sum that wraps changes the kind, sense or size reported one cycle after the last byte. The bench therefore sweeps every byte-9 value, the feature bits, the range boundary and overflowing start blocks, and checks the reported kind, sense, size and fields for each.

// File: rtl/pkt_read_decoder.sv
module pkt_read_decoder #(
  parameter int CAP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       feature,
  input  logic             media_present,
  input  logic [CAP_W-1:0] capacity,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             res_valid,
  output logic [2:0]       res_kind,
  output logic [3:0]       sense_key,
  output logic [7:0]       sense_asc,
  output logic [31:0]      start_lba,
  output logic [23:0]      sect_count,
  output logic [11:0]      sect_size,
  output logic             use_dma,
  output logic [2:0]       int_reason
);
  localparam int PKT_LEN = 12;
  localparam int RW      = (CAP_W + 1 > 35) ? CAP_W + 1 : 35;
  localparam logic [2:0] K_OK = 3'd0, K_READ = 3'd1, K_ERR = 3'd2,
                         K_ABORT = 3'd3, K_OTHER = 3'd4;

  logic [7:0] pkt [PKT_LEN];
  logic [3:0] idx;
  logic       eval_q;
  logic [7:0] feat_q;
  wire        take = in_valid && in_ready;

  assign in_ready = !eval_q;

  always_ff @(posedge clk)
    if (take) pkt[idx] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      eval_q <= 1'b0;
      feat_q <= '0;
    end else begin
      eval_q <= 1'b0;
      if (take) begin
        if (idx == 4'd0) feat_q <= feature;
        if (idx == 4'(PKT_LEN - 1)) begin
          idx    <= '0;
          eval_q <= 1'b1;
        end else begin
          idx <= idx + 4'd1;
        end
      end
    end
  end

  wire [31:0] lba   = {pkt[2], pkt[3], pkt[4], pkt[5]};
  wire [23:0] cnt   = {pkt[6], pkt[7], pkt[8]};
  wire [4:0]  xfer  = pkt[9][7:3];
  wire [RW-1:0] span = (RW'(lba) + RW'(cnt)) << 2;
  wire        range_bad = span > RW'(capacity);

  logic [2:0]  kind_d, reason_d;
  logic [3:0]  key_d;
  logic [7:0]  asc_d;
  logic [11:0] size_d;

  always_comb begin
    kind_d   = K_OK;
    key_d    = 4'd0;
    asc_d    = 8'd0;
    size_d   = 12'd0;
    reason_d = 3'b011;
    if (feat_q[1]) begin
      kind_d   = K_ABORT;
      reason_d = 3'b000;
    end else if (pkt[0] != 8'hBE) begin
      kind_d   = K_OTHER;
      reason_d = 3'b000;
    end else if (!media_present) begin
      kind_d = K_ERR;
      key_d  = 4'd2;
      asc_d  = 8'h3A;
    end else if (cnt == 24'd0) begin
      kind_d = K_OK;
    end else if (range_bad) begin
      kind_d = K_ERR;
      key_d  = 4'd5;
      asc_d  = 8'h21;
    end else begin
      case (xfer)
        5'h00: kind_d = K_OK;
        5'h02: begin kind_d = K_READ; size_d = 12'd2048; reason_d = 3'b010; end
        5'h1F: begin kind_d = K_READ; size_d = 12'd2352; reason_d = 3'b010; end
        default: begin kind_d = K_ERR; key_d = 4'd5; asc_d = 8'h24; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_kind   <= '0;
      sense_key  <= '0;
      sense_asc  <= '0;
      start_lba  <= '0;
      sect_count <= '0;
      sect_size  <= '0;
      use_dma    <= 1'b0;
      int_reason <= '0;
    end else begin
      res_valid <= eval_q;
      if (eval_q) begin
        res_kind   <= kind_d;
        sense_key  <= key_d;
        sense_asc  <= asc_d;
        start_lba  <= lba;
        sect_count <= cnt;
        sect_size  <= size_d;
        use_dma    <= feat_q[0];
        int_reason <= reason_d;
      end
    end
  end
endmodule

// File: rtl/pkt_read_decoder_chk.sv
module pkt_read_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        res_valid,
  input logic [2:0]  res_kind,
  input logic [3:0]  sense_key,
  input logic [7:0]  sense_asc,
  input logic [31:0] start_lba,
  input logic [23:0] sect_count,
  input logic [11:0] sect_size,
  input logic        use_dma,
  input logic [2:0]  int_reason
);
  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R1
  AST_NO_TAKE_BEFORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$past(in_ready)); // R1
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable({res_kind, sense_key, sense_asc, start_lba, sect_count,
                            sect_size, use_dma, int_reason})); // R2
  AST_READ_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 3'd1 |-> sect_size == 12'd2048 || sect_size == 12'd2352); // R8
  AST_ERR_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 3'd2 |-> sense_key == 4'd2 || sense_key == 4'd5); // R5
  AST_QUIET_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind != 3'd2 |-> sense_key == 4'd0 && sense_asc == 8'd0); // R11
  AST_DONE_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_kind == 3'd0 || res_kind == 3'd2) |-> int_reason == 3'b011); // R11
endmodule

bind pkt_read_decoder pkt_read_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .res_valid(res_valid),
  .res_kind(res_kind), .sense_key(sense_key), .sense_asc(sense_asc),
  .start_lba(start_lba), .sect_count(sect_count), .sect_size(sect_size),
  .use_dma(use_dma), .int_reason(int_reason)
);

// File: tb/tb_pkt_read_decoder.sv
`timescale 1ns/1ps
module tb_pkt_read_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] feature = '0;
  logic media_present = 1'b1;
  logic [31:0] capacity = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, res_valid, use_dma;
  logic [2:0] res_kind, int_reason;
  logic [3:0] sense_key;
  logic [7:0] sense_asc;
  logic [31:0] start_lba;
  logic [23:0] sect_count;
  logic [11:0] sect_size;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pkt_read_decoder dut (
    .clk(clk), .rst_n(rst_n), .feature(feature), .media_present(media_present),
    .capacity(capacity), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .res_valid(res_valid), .res_kind(res_kind), .sense_key(sense_key),
    .sense_asc(sense_asc), .start_lba(start_lba), .sect_count(sect_count),
    .sect_size(sect_size), .use_dma(use_dma), .int_reason(int_reason));

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] snap();
    return {7'd0, res_kind, sense_key, sense_asc, start_lba, sect_count, sect_size,
            use_dma, int_reason};
  endfunction

  function automatic logic [95:0] model(input logic [7:0] op, input logic [31:0] lba,
      input logic [23:0] cnt, input logic [7:0] b9, input logic [7:0] f,
      input logic m, input logic [31:0] cap);
    logic [2:0] k; logic [3:0] key; logic [7:0] asc; logic [11:0] sz; logic [2:0] rs;
    logic [63:0] span;
    k = 0; key = 0; asc = 0; sz = 0; rs = 3'b011;
    span = (64'(lba) + 64'(cnt)) * 4;
    if (f[1]) begin k = 3; rs = 0; end
    else if (op != 8'hBE) begin k = 4; rs = 0; end
    else if (!m) begin k = 2; key = 2; asc = 8'h3A; end
    else if (cnt == 0) k = 0;
    else if (span > 64'(cap)) begin k = 2; key = 5; asc = 8'h21; end
    else if ((b9 & 8'hF8) == 8'h00) k = 0;
    else if ((b9 & 8'hF8) == 8'h10) begin k = 1; sz = 2048; rs = 3'b010; end
    else if ((b9 & 8'hF8) == 8'hF8) begin k = 1; sz = 2352; rs = 3'b010; end
    else begin k = 2; key = 5; asc = 8'h24; end
    return {7'd0, k, key, asc, lba, cnt, sz, f[0], rs};
  endfunction

  task automatic send(input logic [95:0] p, input int gap, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      if (gap != 0 && (i % 3) == 1) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = p[95 - 8*i -: 8];
    end
  endtask

  task automatic run(input string tag, input logic [7:0] op, input logic [31:0] lba,
      input logic [23:0] cnt, input logic [7:0] b9, input logic [7:0] f,
      input logic m, input logic [31:0] cap, input int gap);
    logic [95:0] p;
    p = {op, 8'h00, lba, cnt, b9, 16'h0000};
    feature = f; media_present = m; capacity = cap;
    send(p, gap, 0, 11);
    @(negedge clk); in_valid = 1'b0;
    check({tag, " R1 ready low while deciding"}, {95'd0, in_ready}, 96'd0);
    @(negedge clk);
    check({tag, " R1 strobe"}, {95'd0, res_valid}, 96'd1);
    check(tag, snap(), model(op, lba, cnt, b9, f, m, cap));
    @(negedge clk);
    check({tag, " R1 strobe drops"}, {95'd0, res_valid}, 96'd0);
  endtask

  initial begin
    #4000000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [95:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {94'd0, in_ready, res_valid}, 96'd2);
    check("R1 reset fields", snap(), 96'd0);

    for (int b = 0; b < 256; b++)
      run("R8 type sweep", 8'hBE, 32'd10 + b, 24'd3, 8'(b), 8'h00, 1'b1, 32'd5000, 0);

    for (int f = 0; f < 4; f++)
      run("R3 R10 feature", 8'hBE, 32'h0000_0100, 24'd2, 8'hF8, 8'(f | 8'hF0), 1'b1, 32'd5000, f & 1);

    run("R4 opcode 28", 8'h28, 32'd1, 24'd1, 8'h10, 8'h00, 1'b1, 32'd100, 0);
    run("R4 opcode BF", 8'hBF, 32'd1, 24'd1, 8'h10, 8'h00, 1'b1, 32'd100, 0);
    run("R4 opcode 00", 8'h00, 32'd1, 24'd1, 8'h10, 8'h00, 1'b1, 32'd100, 0);
    run("R3 abort beats opcode", 8'h28, 32'd1, 24'd1, 8'h10, 8'h02, 1'b0, 32'd100, 0);

    run("R5 no media zero count", 8'hBE, 32'd0, 24'd0, 8'h08, 8'h00, 1'b0, 32'd100, 0);
    run("R5 no media bad range", 8'hBE, 32'hFFFF_0000, 24'd9, 8'h10, 8'h01, 1'b0, 32'd100, 1);
    run("R6 zero count bad range", 8'hBE, 32'hFFFF_FFFF, 24'd0, 8'h48, 8'h00, 1'b1, 32'd100, 0);
    run("R6 zero count good", 8'hBE, 32'd5, 24'd0, 8'h10, 8'h01, 1'b1, 32'd100, 0);
    run("R7 range beats type", 8'hBE, 32'd200, 24'd1, 8'h48, 8'h00, 1'b1, 32'd100, 0);

    for (int l = 95; l <= 101; l++)
      for (int c = 1; c <= 3; c++)
        run("R7 boundary", 8'hBE, 32'(l), 24'(c), 8'h10, 8'h00, 1'b1, 32'd400, 0);
    run("R7 wrap high start", 8'hBE, 32'hFFFF_FFFF, 24'd1, 8'h10, 8'h00, 1'b1, 32'hFFFF_FFFF, 0);
    run("R7 wrap max both", 8'hBE, 32'hFFFF_FFFF, 24'hFF_FFFF, 8'h10, 8'h00, 1'b1, 32'hFFFF_FFFF, 0);
    run("R7 wrap shift", 8'hBE, 32'h3FFF_FFFF, 24'd1, 8'h10, 8'h00, 1'b1, 32'hFFFF_FFFF, 0);
    run("R7 fits max", 8'hBE, 32'h3FFF_FFFE, 24'd1, 8'hF8, 8'h00, 1'b1, 32'hFFFF_FFFF, 0);
    run("R9 byte order", 8'hBE, 32'h0102_0304, 24'h05_0607, 8'h10, 8'h00, 1'b1, 32'hFFFF_FFFF, 1);

    run("R2 base", 8'hBE, 32'h0000_1234, 24'h00_0042, 8'hF8, 8'h01, 1'b1, 32'h0010_0000, 0);
    held = snap();
    feature = 8'h02; media_present = 1'b0; capacity = 32'd0;
    send({8'h28, 8'h00, 32'hDEAD_BEEF, 24'h0, 8'h08, 16'h0}, 0, 0, 4);
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 fields held mid packet", snap(), held);
    send({8'h28, 8'h00, 32'hDEAD_BEEF, 24'h0, 8'h08, 16'h0}, 0, 5, 11);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check("R3 held packet result", snap(),
          model(8'h28, 32'hDEAD_BEEF, 24'h0, 8'h08, 8'h02, 1'b0, 32'd0));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule